// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox Controller

This block is a register-mapped mailbox that lets several processors pass 32-bit words to each other. It holds a set of small hardware queues. A processor sends a word by writing a queue's message register and takes the oldest word by reading the same register. Each queue also has a read-only full flag and a read-only word count, so software can poll instead of waiting for an interrupt.

Every processor, called a user here, has its own interrupt status and enable words. Each queue has two events, one raised when a word arrives and one raised when a pop takes the queue from full to not full. Both events are raised in every user's status word. Each user has one interrupt line that is active while any of its enabled events is pending. A build parameter picks one of two enable layouts. The first has one enable register per user that software rewrites as a whole. The second has separate set and clear registers, placed in a wider per-user stride.

The register port is a single-cycle request interface: `bus_req` together with `bus_we`, `bus_addr` and `bus_wdata`. Read data is registered.

Top module: `mbox_ctrl`

## Requirements
- R1: A read of offset 0x000 returns the `REV_ID` parameter value (default 32'h0000_0102).
- R2: A write to offset 0x040+4·m pushes `bus_wdata` into queue m. A read of that offset pops queue m and returns its oldest word. Words come out in the order they were written. Read data appears on `bus_rdata` one clock after the read request is accepted.
- R3: Bit 0 of offset 0x080+4·m reads 1 exactly when queue m holds `QUEUE_DEPTH` words (default 4). All other bits read 0.
- R4: Offset 0x0C0+4·m returns the number of words currently held in queue m.
- R5: A push to a full queue is discarded. The count and the stored words are unchanged.
- R6: A pop from an empty queue returns 0 and the count stays at 0.
- R7: An accepted push into queue m sets status bit 2·m in every user's status word. A pop from a full queue m sets bit 2·m+1 in every user's status word.
- R8: Writing to a status register clears each status bit written as 1 and leaves the bits written as 0 unchanged. A read on the following cycle already shows the cleared value.
- R9: With `LAYOUT` = LAYOUT_RMW, user u's status is at 0x100+8·u. Its enable register is at 0x104+8·u; a write replaces the enable word and a read returns it.
- R10: With `LAYOUT` = LAYOUT_SETCLR, user u's status is at 0x104+16·u. Writing 1s at 0x108+16·u sets those enable bits, and writing 1s at 0x10C+16·u clears them. Both offsets read back the enable word. Offset 0x100 is unmapped in this layout.
- R11: `irq[u]` is high exactly when user u has a status bit set whose enable bit is also set. It is low after reset.
- R12: A read of any unmapped offset returns 0. A write to an unmapped offset changes no queue, status or enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the request |
| irq | output | NUM_USERS | One interrupt line per user |

## Verification
A write takes effect at the clock edge that accepts it. Queue contents, counts, status bits and enables are therefore updated by that edge, and `irq` follows at once because it is combinational from those registers. A read result is captured at the accepting edge and held on `bus_rdata` from then on. The bench drives every request on a falling edge, holds it through one rising edge, and samples `bus_rdata` and `irq` at the next falling edge. Each comparison therefore lands in the first cycle where the result is due and before the next request can disturb it. A random access stream on the first layout is compared against a bench model of the queues, status words and enables. Directed sequences cover full and empty queues, clearing status bits, and the second layout.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned MAX_Q   = 16;
    localparam int unsigned MAX_U   = 16;
    localparam int unsigned IDX_W   = 5;

    localparam logic [ADDR_W-1:0] OFS_REV  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_MSG  = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_FULL = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 12'h0C0;
    localparam logic [ADDR_W-1:0] OFS_IRQ  = 12'h100;

    typedef enum logic {
        LAYOUT_RMW    = 1'b0,
        LAYOUT_SETCLR = 1'b1
    } irq_layout_e;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_REV,
        ACC_MSG,
        ACC_FULL,
        ACC_CNT,
        ACC_STAT,
        ACC_EN,
        ACC_ENSET,
        ACC_ENCLR
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } acc_t;

    // Map an offset to the register kind and the queue or user index.
    function automatic acc_t decode_addr(input logic [ADDR_W-1:0] a,
                                         input int unsigned nq,
                                         input int unsigned nu,
                                         input irq_layout_e lay);
        acc_t r;
        r.kind = ACC_NONE;
        r.idx  = '0;
        if (a == OFS_REV) r.kind = ACC_REV;
        for (int m = 0; m < MAX_Q; m++) begin
            if (m < int'(nq)) begin
                if (a == OFS_MSG + 12'(4*m))  begin r.kind = ACC_MSG;  r.idx = IDX_W'(m); end
                if (a == OFS_FULL + 12'(4*m)) begin r.kind = ACC_FULL; r.idx = IDX_W'(m); end
                if (a == OFS_CNT + 12'(4*m))  begin r.kind = ACC_CNT;  r.idx = IDX_W'(m); end
            end
        end
        for (int u = 0; u < MAX_U; u++) begin
            if (u < int'(nu)) begin
                if (lay == LAYOUT_RMW) begin
                    if (a == OFS_IRQ + 12'(8*u))     begin r.kind = ACC_STAT;  r.idx = IDX_W'(u); end
                    if (a == OFS_IRQ + 12'(8*u+4))   begin r.kind = ACC_EN;    r.idx = IDX_W'(u); end
                end else begin
                    if (a == OFS_IRQ + 12'(16*u+4))  begin r.kind = ACC_STAT;  r.idx = IDX_W'(u); end
                    if (a == OFS_IRQ + 12'(16*u+8))  begin r.kind = ACC_ENSET; r.idx = IDX_W'(u); end
                    if (a == OFS_IRQ + 12'(16*u+12)) begin r.kind = ACC_ENCLR; r.idx = IDX_W'(u); end
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 32,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
    parameter int unsigned EVW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [EVW-1:0] evt,
    input  logic [EVW-1:0] ack,
    input  logic           en_load,
    input  logic [EVW-1:0] en_val,
    input  logic [EVW-1:0] en_set,
    input  logic [EVW-1:0] en_clr,
    output logic [EVW-1:0] status,
    output logic [EVW-1:0] enable,
    output logic           irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~ack) | evt;
            if (en_load) enable <= en_val;
            else         enable <= (enable | en_set) & ~en_clr;
        end
    end

    assign irq = |(status & enable);
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_QUEUES  = 8,
    parameter int unsigned NUM_USERS   = 4,
    parameter int unsigned QUEUE_DEPTH = 4,
    parameter irq_layout_e LAYOUT      = LAYOUT_RMW,
    parameter logic [31:0] REV_ID      = 32'h0000_0102
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_USERS-1:0] irq
);
    localparam int unsigned EVW = 2 * NUM_QUEUES;
    localparam int unsigned CW  = $clog2(QUEUE_DEPTH + 1);

    acc_t acc;
    logic wr, rd;
    logic [31:0] rd_val;

    assign acc = decode_addr(bus_addr, NUM_QUEUES, NUM_USERS, LAYOUT);
    assign wr  = bus_req && bus_we;
    assign rd  = bus_req && !bus_we;

    logic [NUM_QUEUES-1:0]           q_push, q_pop, q_full, q_empty;
    logic [NUM_QUEUES-1:0][31:0]     q_head;
    logic [NUM_QUEUES-1:0][CW-1:0]   q_cnt;
    logic [EVW-1:0]                  evt;
    logic [NUM_USERS-1:0][EVW-1:0]   st, en;

    for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_queue
        logic hit;
        assign hit       = (acc.kind == ACC_MSG) && (acc.idx == IDX_W'(g));
        assign q_push[g] = wr && hit && !q_full[g];
        assign q_pop[g]  = rd && hit && !q_empty[g];
        assign evt[2*g]   = q_push[g];
        assign evt[2*g+1] = q_pop[g] && q_full[g];

        mbox_fifo #(.DEPTH(QUEUE_DEPTH), .W(32)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[g]),
            .pop   (q_pop[g]),
            .din   (bus_wdata),
            .head  (q_head[g]),
            .count (q_cnt[g]),
            .full  (q_full[g]),
            .empty (q_empty[g])
        );
    end

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
        logic hit;
        assign hit = (acc.idx == IDX_W'(u));

        mbox_user_irq #(.EVW(EVW)) u_irq (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt),
            .ack     ((wr && hit && acc.kind == ACC_STAT)  ? bus_wdata[EVW-1:0] : '0),
            .en_load (wr && hit && acc.kind == ACC_EN),
            .en_val  (bus_wdata[EVW-1:0]),
            .en_set  ((wr && hit && acc.kind == ACC_ENSET) ? bus_wdata[EVW-1:0] : '0),
            .en_clr  ((wr && hit && acc.kind == ACC_ENCLR) ? bus_wdata[EVW-1:0] : '0),
            .status  (st[u]),
            .enable  (en[u]),
            .irq     (irq[u])
        );
    end

    always_comb begin
        rd_val = '0;
        if (acc.kind == ACC_REV) rd_val = REV_ID;
        for (int m = 0; m < NUM_QUEUES; m++) begin
            if (acc.idx == IDX_W'(m)) begin
                case (acc.kind)
                    ACC_MSG:  rd_val = q_empty[m] ? '0 : q_head[m];
                    ACC_FULL: rd_val = {31'b0, q_full[m]};
                    ACC_CNT:  rd_val = 32'(q_cnt[m]);
                    default:  ;
                endcase
            end
        end
        for (int u = 0; u < NUM_USERS; u++) begin
            if (acc.idx == IDX_W'(u)) begin
                case (acc.kind)
                    ACC_STAT:                   rd_val = 32'(st[u]);
                    ACC_EN, ACC_ENSET, ACC_ENCLR: rd_val = 32'(en[u]);
                    default:                    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/mbox_ctrl_chk.sv
module mbox_ctrl_chk #(
    parameter int unsigned NQ    = 8,
    parameter int unsigned NU    = 4,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CW    = 3,
    parameter int unsigned EVW   = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_req,
    input logic                  bus_we,
    input logic [11:0]           bus_addr,
    input logic [31:0]           bus_rdata,
    input logic [NU-1:0]         irq,
    input logic [NQ-1:0][CW-1:0] q_cnt,
    input logic [NU-1:0][EVW-1:0] st,
    input logic [NU-1:0][EVW-1:0] en
);
    for (genvar m = 0; m < NQ; m++) begin : g_q
        logic msg_wr, msg_rd;
        assign msg_wr = bus_req &&  bus_we && (bus_addr == 12'(64 + 4*m));
        assign msg_rd = bus_req && !bus_we && (bus_addr == 12'(64 + 4*m));

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            q_cnt[m] <= CW'(DEPTH)); // R5
        AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (rst)
            (msg_wr && q_cnt[m] == CW'(DEPTH)) |=> $stable(q_cnt[m])); // R5
        AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
            (msg_rd && q_cnt[m] == '0) |=> (bus_rdata == '0 && q_cnt[m] == '0)); // R6
        AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (rst)
            (msg_wr && q_cnt[m] < CW'(DEPTH)) |=> (q_cnt[m] == $past(q_cnt[m]) + CW'(1))); // R4

        for (genvar u = 0; u < NU; u++) begin : g_u
            AST_NEWMSG_FLAG: assert property (@(posedge clk) disable iff (rst)
                (msg_wr && q_cnt[m] < CW'(DEPTH)) |=> st[u][2*m]); // R7
            AST_NOTFULL_FLAG: assert property (@(posedge clk) disable iff (rst)
                (msg_rd && q_cnt[m] == CW'(DEPTH)) |=> st[u][2*m+1]); // R7
        end
    end

    for (genvar u = 0; u < NU; u++) begin : g_irq
        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
            (en[u] == '0) |-> !irq[u]); // R11
        AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (rst)
            irq[u] |-> (st[u] != '0)); // R11
    end
endmodule

bind mbox_ctrl mbox_ctrl_chk #(
    .NQ(NUM_QUEUES), .NU(NUM_USERS), .DEPTH(QUEUE_DEPTH), .CW(CW), .EVW(EVW)
) u_chk (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .irq(irq), .q_cnt(q_cnt), .st(st), .en(en)
);

// File: tb/mbox_ctrl_bench.sv
`timescale 1ns/1ps
module mbox_ctrl_bench;
    import mbox_pkg::*;

    localparam int NQ = 8;
    localparam int NU = 4;
    localparam int D  = 4;
    localparam logic [31:0] REV = 32'h0000_0102;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_a = 1'b0, req_b = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic [NU-1:0] irq_a, irq_b;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mbox_ctrl #(.NUM_QUEUES(NQ), .NUM_USERS(NU), .QUEUE_DEPTH(D),
                .LAYOUT(LAYOUT_RMW), .REV_ID(REV)) u_mbox_ctrl (
        .clk(clk), .rst(rst), .bus_req(req_a), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .irq(irq_a));

    mbox_ctrl #(.NUM_QUEUES(NQ), .NUM_USERS(NU), .QUEUE_DEPTH(D),
                .LAYOUT(LAYOUT_SETCLR), .REV_ID(REV)) u_mbox_ctrl_l2 (
        .clk(clk), .rst(rst), .bus_req(req_b), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .irq(irq_b));

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit b, input bit w, input logic [11:0] a,
                          input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        req_a = !b; req_b = b; we = w; addr = a; wdata = d;
        @(negedge clk);
        req_a = 1'b0; req_b = 1'b0; we = 1'b0;
        r = b ? rdata_b : rdata_a;
    endtask

    task automatic wr(input bit b, input logic [11:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        access(b, 1'b1, a, d, dummy);
    endtask

    task automatic rd(input bit b, input logic [11:0] a, output logic [31:0] r);
        access(b, 1'b0, a, '0, r);
    endtask

    // Reference model of the first-layout instance
    logic [31:0] mq [NQ][$];
    logic [15:0] mst [NU];
    logic [15:0] men [NU];

    function automatic logic [NU-1:0] exp_irq();
        logic [NU-1:0] r;
        for (int u = 0; u < NU; u++) r[u] = |(mst[u] & men[u]);
        return r;
    endfunction

    function automatic logic [11:0] a_msg(input int m);  return 12'(64 + 4*m);   endfunction
    function automatic logic [11:0] a_full(input int m); return 12'(128 + 4*m);  endfunction
    function automatic logic [11:0] a_cnt(input int m);  return 12'(192 + 4*m);  endfunction
    function automatic logic [11:0] a_st(input int u);   return 12'(256 + 8*u);  endfunction
    function automatic logic [11:0] a_en(input int u);   return 12'(260 + 8*u);  endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < NQ; m++) mq[m].delete();
        for (int u = 0; u < NU; u++) begin mst[u] = '0; men[u] = '0; end
    endtask

    task automatic op_push(input int m, input logic [31:0] d);
        wr(1'b0, a_msg(m), d);
        if (mq[m].size() < D) begin
            mq[m].push_back(d);
            for (int u = 0; u < NU; u++) mst[u][2*m] = 1'b1;
        end
    endtask

    task automatic op_pop(input int m, input string tag);
        logic [31:0] r, e;
        rd(1'b0, a_msg(m), r);
        e = '0;
        if (mq[m].size() > 0) begin
            if (mq[m].size() == D)
                for (int u = 0; u < NU; u++) mst[u][2*m+1] = 1'b1;
            e = mq[m].pop_front();
        end
        check(tag, r, e);
    endtask

    task automatic op_cnt(input int m);
        logic [31:0] r;
        rd(1'b0, a_cnt(m), r);
        check("R4 count", r, 32'(mq[m].size()));
        rd(1'b0, a_full(m), r);
        check("R3 full", r, {31'b0, mq[m].size() == D});
    endtask

    task automatic op_stat(input int u);
        logic [31:0] r;
        rd(1'b0, a_st(u), r);
        check("R7 status", r, 32'(mst[u]));
    endtask

    task automatic op_ack(input int u, input logic [15:0] v);
        wr(1'b0, a_st(u), 32'(v));
        mst[u] = mst[u] & ~v;
    endtask

    task automatic op_en(input int u, input logic [15:0] v);
        logic [31:0] r;
        wr(1'b0, a_en(u), 32'(v));
        men[u] = v;
        rd(1'b0, a_en(u), r);
        check("R9 enable", r, 32'(v));
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_0042));
        do_reset();

        // Reset state
        check("R11 reset irq", 32'(irq_a), 32'(exp_irq()));
        check("R2 reset rdata", rdata_a, 32'h0);
        op_cnt(0);

        // Revision
        rd(1'b0, 12'h000, r); check("R1 revision", r, REV);
        rd(1'b1, 12'h000, r); check("R1 revision l2", r, REV);

        // Fill queue 3, overflow, drain, underflow
        for (int i = 0; i < D; i++) op_push(3, 32'hA000_0000 + 32'(i));
        op_cnt(3);
        op_stat(0);
        op_stat(2);
        op_push(3, 32'hDEAD_BEEF);
        rd(1'b0, a_cnt(3), r); check("R5 drop on full", r, 32'(D));
        for (int i = 0; i < D; i++) op_pop(3, "R2 fifo order");
        op_stat(1);
        op_pop(3, "R6 pop empty");
        rd(1'b0, a_cnt(3), r); check("R6 count stays 0", r, 32'h0);

        // Write-one-to-clear, one bit at a time
        op_ack(0, 16'h0040);
        rd(1'b0, a_st(0), r); check("R8 partial clear", r, 32'(mst[0]));
        op_ack(0, 16'h0080);
        rd(1'b0, a_st(0), r); check("R8 full clear", r, 32'h0);

        // Enable (read-modify-write layout) and interrupt line
        op_en(0, 16'h0001);
        check("R11 irq idle", 32'(irq_a), 32'h0);
        op_push(0, 32'h1234_5678);
        check("R11 irq raised", 32'(irq_a), 32'(exp_irq()));
        op_ack(0, 16'h0001);
        check("R11 irq cleared", 32'(irq_a), 32'h0);

        // Unmapped offsets
        rd(1'b0, 12'h03C, r); check("R12 unmapped read", r, 32'h0);
        rd(1'b0, 12'h0E0, r); check("R12 unmapped read", r, 32'h0);
        rd(1'b0, 12'h200, r); check("R12 unmapped read", r, 32'h0);
        wr(1'b0, 12'h060, 32'hFFFF_FFFF);
        wr(1'b0, 12'h0FC, 32'hFFFF_FFFF);
        wr(1'b0, 12'h120, 32'hFFFF_FFFF);
        rd(1'b0, a_cnt(0), r); check("R12 write ignored count", r, 32'h1);
        rd(1'b0, a_st(0), r);  check("R12 write ignored status", r, 32'h0);
        rd(1'b0, a_en(0), r);  check("R12 write ignored enable", r, 32'h1);

        // Second layout on the other instance
        wr(1'b1, 12'h118, 32'h13);
        rd(1'b1, 12'h118, r); check("R10 enable set", r, 32'h13);
        wr(1'b1, 12'h11C, 32'h02);
        rd(1'b1, 12'h11C, r); check("R10 enable clear", r, 32'h11);
        check("R11 l2 idle", 32'(irq_b), 32'h0);
        wr(1'b1, 12'h048, 32'hCAFE_0002);
        rd(1'b1, 12'h114, r); check("R10 status offset", r, 32'h10);
        check("R11 l2 raised", 32'(irq_b), 32'h2);
        rd(1'b1, 12'h100, r); check("R10 offset 0x100 unmapped", r, 32'h0);
        wr(1'b1, 12'h114, 32'h10);
        rd(1'b1, 12'h114, r); check("R8 l2 clear", r, 32'h0);
        check("R11 l2 dropped", 32'(irq_b), 32'h0);

        // Random traffic on the first layout
        do_reset();
        for (int n = 0; n < 600; n++) begin
            int op, m, u;
            op = $urandom_range(0, 9);
            m  = $urandom_range(0, NQ - 1) % 3;
            u  = $urandom_range(0, NU - 1);
            case (op)
                0, 1, 2, 3: op_push(m, $urandom);
                4, 5:       op_pop(m, "R2 random pop");
                6:          op_cnt(m);
                7:          op_stat(u);
                8:          op_ack(u, 16'($urandom));
                default:    op_en(u, 16'($urandom));
            endcase
            check("R11 random irq", 32'(irq_a), 32'(exp_irq()));
        end

        done = 1'b1;
        report();
    end
endmodule